// File: doc/BRIEF.md
# Variable-Length Serial Frame Transmitter

This block drives one asynchronous serial line. Each parallel word offered on a valid/ready handshake becomes one frame: a low start slot, a body of 7, 8 or 9 slots chosen by a 2-bit length code, and a closing high stop slot. When parity is switched on, the last body slot carries a parity bit instead of data, so one data bit fewer goes out. Two strobes ask for special frames. An idle frame keeps the line high for a whole frame time. A break frame drives the line low through the start and body slots and then releases it for the stop slot.

Slot timing comes entirely from an external baud tick. Every tick moves the line on by one slot. A new frame begins on the tick that closes the previous stop slot, or on any later tick once work is pending. Words wait in one storage array. With queue mode on, the array acts as an 8-entry queue, 9 bits wide. With queue mode off, only one entry is used as a holding register.

Top module: `uart_wordlen_tx`

## Requirements
- R1: Length code 2'b00 gives a body of 8 slots, 2'b01 gives 9 slots, 2'b10 gives 7 slots, and the reserved code 2'b11 behaves like 2'b00. The code is sampled when a frame is loaded.
- R2: A data frame is one low start slot, the data bits least significant first, then one high stop slot. Each slot lasts exactly one baud-tick interval.
- R3: With parity on, the last body slot holds the parity bit and the slot before it holds the last data bit. With even parity selected (odd-select low), the ones across data and parity add up to an even count. With odd parity selected, they add up to an odd count.
- R4: An idle frame holds the line high for the body length plus two slots.
- R5: A break frame holds the line low for the body length plus one slot, then sends one high stop slot.
- R6: A pending break is served before a pending idle, and a pending idle is served before queued data. Each strobe yields exactly one special frame.
- R7: The line rests high whenever busy is low. The line changes only in the cycle after a baud tick.
- R8: With queue mode on, up to 8 words are accepted and sent in order. Ready drops while 8 words are held, and a word offered while ready is low is dropped.
- R9: With queue mode off, ready drops after one word is accepted and stays low until that word's frame is loaded. A word offered meanwhile is dropped.
- R10: When more work is pending, the next frame starts on the tick that ends the current stop slot, with no gap slot.
- R11: After reset the line is high, busy is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1: 8-entry queue, 0: single holding register |
| len_code | input | 2 | Body length select |
| par_en | input | 1 | Parity in last body slot |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| in_data | input | 9 | Word to send, bit 0 first |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted |
| idle_req | input | 1 | One-cycle strobe requesting an idle frame |
| brk_req | input | 1 | One-cycle strobe requesting a break frame |
| baud_tick | input | 1 | One-cycle slot advance enable |
| tx | output | 1 | Serial line |
| busy | output | 1 | Frame in progress or work pending |

## Verification
The line takes on a new slot value in the first cycle after the clock edge that sees a tick. The bench therefore samples the line once per tick, half a cycle after that edge, and builds a slot stream. Ticks are held off while requests and words are loaded, so the first tick must start the first frame, and the stream must equal the bench's own concatenation of frames with no gaps. One extra slot after the stream must show a high line and busy low. Ready is read half a cycle after each accepting edge, which is the cycle in which it is due to fall.

// File: rtl/uart_wordlen_tx.sv
module uart_wordlen_tx #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [8:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       idle_req,
  input  logic       brk_req,
  input  logic       baud_tick,
  output logic       tx,
  output logic       busy
);
  localparam int DW = 9;
  localparam int FW = DW + 2;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt_q, cap;
  logic [FW-1:0] sh, frm;
  logic [3:0]    slots;
  logic          brk_p, idl_p;
  logic [3:0]    nb;
  logic [DW-1:0] word, dmask;
  logic          par;

  assign cap      = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign in_ready = cnt_q < cap;
  assign tx       = (slots != 4'd0) ? sh[0] : 1'b1;
  assign busy     = (slots != 4'd0) || brk_p || idl_p || (cnt_q != '0);

  wire push     = in_valid && in_ready;
  wire start    = baud_tick && (slots <= 4'd1);
  wire take_brk = start && brk_p;
  wire take_idl = start && !brk_p && idl_p;
  wire take_dat = start && !brk_p && !idl_p && (cnt_q != '0);

  always_comb begin
    case (len_code)
      2'b01:   nb = 4'd9;
      2'b10:   nb = 4'd7;
      default: nb = 4'd8;
    endcase
  end

  assign word = mem[rp];

  always_comb begin
    for (int i = 0; i < DW; i++) dmask[i] = (i < int'(nb) - 1);
    par = ^(word & dmask) ^ par_odd;
    frm = '1;
    for (int i = 0; i < FW; i++) begin
      if (take_brk) begin
        frm[i] = (i > int'(nb));
      end else if (!take_idl) begin
        if (i == 0) frm[i] = 1'b0;
        else if (i <= int'(nb)) frm[i] = (par_en && i == int'(nb)) ? par : word[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
      sh    <= '1;
      slots <= 4'd0;
      brk_p <= 1'b0;
      idl_p <= 1'b0;
    end else begin
      brk_p <= brk_req | (brk_p & ~take_brk);
      idl_p <= idle_req | (idl_p & ~take_idl);
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (take_dat) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !take_dat) cnt_q <= cnt_q + 1'b1;
      else if (!push && take_dat) cnt_q <= cnt_q - 1'b1;
      if (baud_tick) begin
        if (slots > 4'd1) begin
          sh    <= {1'b1, sh[FW-1:1]};
          slots <= slots - 4'd1;
        end else if (take_brk || take_idl || take_dat) begin
          sh    <= frm;
          slots <= nb + 4'd2;
        end else begin
          slots <= 4'd0;
        end
      end
    end
  end

  a_r7_rest_high: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> tx);
  a_r7_tick_only: assert property (@(posedge clk) disable iff (!rst_n) !baud_tick |=> $stable(tx));
  a_r5_break_low: assert property (@(posedge clk) disable iff (!rst_n) take_brk |=> !tx);
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n) take_idl |=> tx);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n) take_dat |=> !tx);
  a_r6_one_break: assert property (@(posedge clk) disable iff (!rst_n) (take_brk && !brk_req) |=> !brk_p);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(DEPTH));
  a_r9_single_hold: assert property (@(posedge clk) disable iff (!rst_n) (!fifo_mode && push) |=> !in_ready);
endmodule

// File: tb/uart_wordlen_tx_test.sv
module uart_wordlen_tx_test;
  localparam int PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       fifo_mode = 0, par_en = 0, par_odd = 0;
  logic [1:0] len_code = 0;
  logic [8:0] in_data = 0;
  logic       in_valid = 0, idle_req = 0, brk_req = 0, baud_tick = 0;
  logic       in_ready, tx, busy;

  uart_wordlen_tx uut (.clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .len_code(len_code),
    .par_en(par_en), .par_odd(par_odd), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .idle_req(idle_req), .brk_req(brk_req), .baud_tick(baud_tick),
    .tx(tx), .busy(busy));

  always #(PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit tick_en = 0;
  int tdiv = 0;
  logic [511:0] got_v, bsy_v, exp_v;
  int got_n = 0, exp_n = 0;
  logic [8:0] wq [16];

  always @(negedge clk) begin
    if (baud_tick) begin
      if (got_n < 512) begin got_v[got_n] = tx; bsy_v[got_n] = busy; end
      got_n++;
    end
    baud_tick = 0;
    if (tick_en) begin
      if (tdiv == 3) begin baud_tick = 1; tdiv = 0; end
      else tdiv++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic add_bit(logic b);
    exp_v[exp_n] = b;
    exp_n++;
  endtask

  function automatic int body_len(logic [1:0] lc);
    if (lc == 2'b01) return 9;
    if (lc == 2'b10) return 7;
    return 8;
  endfunction

  task automatic add_frame(int kind, logic [8:0] d);
    int n, nd, ones;
    n = body_len(len_code);
    if (kind == 1) begin
      for (int i = 0; i < n + 2; i++) add_bit(1'b1);
    end else if (kind == 2) begin
      for (int i = 0; i < n + 1; i++) add_bit(1'b0);
      add_bit(1'b1);
    end else begin
      nd = par_en ? n - 1 : n;
      ones = 0;
      add_bit(1'b0);
      for (int i = 0; i < nd; i++) begin add_bit(d[i]); ones += int'(d[i]); end
      if (par_en) add_bit(par_odd ? ~ones[0] : ones[0]);
      add_bit(1'b1);
    end
  endtask

  task automatic push_now(logic [8:0] d);
    @(negedge clk); in_valid = 1; in_data = d;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic run_case(string req, bit br, bit id, int npre, int ntot);
    int bad;
    exp_n = 0; got_n = 0; tdiv = 0;
    if (br) add_frame(2, 0);
    if (id) add_frame(1, 0);
    for (int k = 0; k < ntot; k++) add_frame(0, wq[k]);
    fork
      begin
        for (int k = npre; k < ntot; k++) begin
          @(negedge clk);
          while (!in_ready) @(negedge clk);
          in_valid = 1; in_data = wq[k];
          @(negedge clk); in_valid = 0;
        end
      end
      begin
        @(negedge clk); brk_req = br; idle_req = id;
        @(negedge clk); brk_req = 0; idle_req = 0;
        repeat (20) @(negedge clk);
        tick_en = 1;
        wait (got_n >= exp_n + 1);
        tick_en = 0;
      end
    join
    bad = -1;
    for (int i = 0; i < exp_n; i++) if (bad < 0 && got_v[i] !== exp_v[i]) bad = i;
    check(bad < 0, req, $sformatf("slot stream mismatch at slot %0d", bad),
          (bad < 0) ? 0 : int'(got_v[bad]), (bad < 0) ? 0 : int'(exp_v[bad]));
    check(got_v[exp_n] === 1'b1 && bsy_v[exp_n] === 1'b0, "R7",
          $sformatf("%s tail slot line/busy", req), {got_v[exp_n], bsy_v[exp_n]}, 2);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R11", "reset line/busy/ready",
          {tx, busy, in_ready}, 5);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R2 lengths
    len_code = 2'b00; wq[0] = 9'h0A5; run_case("R1 R2 len8", 0, 0, 0, 1);
    len_code = 2'b01; wq[0] = 9'h1C3; run_case("R1 len9", 0, 0, 0, 1);
    len_code = 2'b10; wq[0] = 9'h155; run_case("R1 len7", 0, 0, 0, 1);
    len_code = 2'b11; wq[0] = 9'h03C; run_case("R1 len reserved", 0, 0, 0, 1);
    // R3 parity
    len_code = 2'b00; par_en = 1; par_odd = 0; wq[0] = 9'h035; run_case("R3 even", 0, 0, 0, 1);
    len_code = 2'b01; par_odd = 1; wq[0] = 9'h0FF; run_case("R3 odd", 0, 0, 0, 1);
    len_code = 2'b10; par_odd = 0; wq[0] = 9'h001; run_case("R3 even len7", 0, 0, 0, 1);
    par_en = 0; len_code = 2'b00;
    // R4 R5 R6 specials
    run_case("R4 idle", 0, 1, 0, 0);
    run_case("R5 break", 1, 0, 0, 0);
    len_code = 2'b01; wq[0] = 9'h12D;
    run_case("R6 break before idle before data", 1, 1, 0, 1);
    len_code = 2'b00;
    // R8 queue full
    fifo_mode = 1;
    for (int k = 0; k < 8; k++) begin wq[k] = 9'(k * 37 + 5); push_now(wq[k]); end
    check(in_ready === 1'b0, "R8", "ready with 8 held", int'(in_ready), 0);
    push_now(9'h1FF);
    check(in_ready === 1'b0, "R8", "ready after dropped offer", int'(in_ready), 0);
    run_case("R8 R10 queue order", 0, 0, 8, 8);
    // R9 holding register
    fifo_mode = 0; wq[0] = 9'h066;
    push_now(wq[0]);
    check(in_ready === 1'b0, "R9", "ready with word held", int'(in_ready), 0);
    push_now(9'h0F0);
    run_case("R9 single hold", 0, 0, 1, 1);
    for (int k = 0; k < 4; k++) wq[k] = 9'(9'h0C3 ^ (k * 9'h051));
    run_case("R10 back to back hold", 0, 0, 0, 4);

    // random mix
    void'($urandom(32'd1234));
    for (int it = 0; it < 24; it++) begin
      int nw;
      bit br, id;
      fifo_mode = 1'($urandom);
      len_code  = 2'($urandom);
      par_en    = 1'($urandom);
      par_odd   = 1'($urandom);
      br = ($urandom % 4) == 0;
      id = ($urandom % 4) == 0;
      nw = 1 + int'($urandom % 6);
      for (int k = 0; k < nw; k++) wq[k] = 9'($urandom);
      run_case("R1 R2 R3 R10 random", br, id, 0, nw);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule